// File: doc/BRIEF.md
# Dual-Family Comparison-Rate Divider

This block turns a reference clock into the phase-comparison rate of a frequency synthesiser loop. A 4-bit select picks one of sixteen division ratios. The top bit chooses the family: either powers of two from 2 to 256, or the mixed sequence 3, 5, 10, 20, 40, 80, 160, 320. The low three bits pick the step within the family.

The block has two outputs. One is a single-cycle strobe that marks the end of each divided period; it is meant for the phase comparator. The other is a square wave that is high for the first half of each period; it is meant to be routed to an observation pin.

A new select takes effect only at a period boundary. Every period therefore has exactly the length of one of the sixteen ratios, so no period is ever short or runt. The asynchronous active-low reset is released through a two-stage synchroniser. After reset the block starts in the divide-by-2 state.

Top module: `rdiv_cmp_divider`

## Requirements
- R1: With sel_i[3] = 0 and sel_i[2:0] = k, the distance between consecutive strobes is 2^(k+1) reference cycles, so the ratios run from 2 (k = 0) to 256 (k = 7).
- R2: With sel_i[3] = 1 and sel_i[2:0] = k, the distance between consecutive strobes is 3 for k = 0, and 5·2^(k-1) for k = 1 to 7, so the ratios run 3, 5, 10, 20, 40, 80, 160, 320.
- R3: strobe_o is high for exactly one reference cycle per divided period, and is low in every other cycle of that period.
- R4: sel_i is sampled only on the clock edge that ends a strobe cycle, and the ratio it selects governs the period that starts on that edge.
- R5: Changes of sel_i during any non-strobe cycle have no effect on the length of the period in progress.
- R6: In a period of ratio r, square_o is high for the first floor(r/2) cycles after the strobe cycle and low for the remaining cycles, including the next strobe cycle.
- R7: While rst_ni is low, strobe_o is 0 and square_o is 1, which is the divide-by-2 state. After rst_ni rises, the first strobe appears in the cycle that follows the third rising clock edge.
- R8: Driving rst_ni low forces both outputs to their reset values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 4 | Ratio select: bit 3 picks the family, bits 2:0 pick the step |
| strobe_o | output | 1 | One-cycle comparison strobe per divided period |
| square_o | output | 1 | Near-50% duty square wave at the divided rate |

## Verification
The countdown state and the latched ratio are internal, so a fault in either one shows up at the ports only as a wrong strobe spacing or a wrong high-time of square_o. Such a fault appears at the latest by the end of the period it corrupts. The bench therefore measures the length and the high-time of every period against an expected-ratio queue.

A select that leaks in mid-period changes the length of the period in progress, so the bench deliberately drives illegal values during periods. A wrong reset value or a wrong synchroniser depth moves the first strobe away from its fixed cycle after reset release, so the bench pins that cycle down exactly.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned STEP_W    = SEL_W - 1;
  localparam int unsigned RATIO_MAX = 320;
  localparam int unsigned RATIO_W   = $clog2(RATIO_MAX + 1);

  typedef logic [RATIO_W-1:0] ratio_t;

  localparam ratio_t RESET_RATIO = ratio_t'(2);
endpackage

// File: rtl/rdiv_rst_sync.sv
module rdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb chain_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/rdiv_ratio_dec.sv
module rdiv_ratio_dec
  import rdiv_pkg::*;
#(
  parameter int unsigned EVEN_BASE = 2,
  parameter int unsigned ODD_FIRST = 3,
  parameter int unsigned ODD_BASE  = 5
) (
  input  logic [SEL_W-1:0] sel_i,
  output ratio_t           ratio_o
);
  logic [STEP_W-1:0] step;
  logic              odd_family;

  assign step       = sel_i[STEP_W-1:0];
  assign odd_family = sel_i[SEL_W-1];

  always_comb begin
    if (!odd_family) begin
      ratio_o = ratio_t'(EVEN_BASE) << step;
    end else if (step == '0) begin
      ratio_o = ratio_t'(ODD_FIRST);
    end else begin
      ratio_o = ratio_t'(ODD_BASE) << (step - STEP_W'(1));
    end
  end
endmodule

// File: rtl/rdiv_core.sv
module rdiv_core
  import rdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t new_ratio_i,
  output logic   strobe_o,
  output logic   square_o
);
  ratio_t cnt_q, cnt_d;
  ratio_t ratio_q;
  ratio_t half_up;
  logic   tc;
  logic   ratio_en;

  assign tc       = (cnt_q == '0);
  assign ratio_en = tc;

  // next-state
  always_comb begin
    if (tc) cnt_d = new_ratio_i - ratio_t'(1);
    else    cnt_d = cnt_q - ratio_t'(1);
  end

  // counter register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RESET_RATIO - ratio_t'(1);
    else         cnt_q <= cnt_d;
  end

  // ratio register with explicit enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ratio_q <= RESET_RATIO;
    else if (ratio_en) ratio_q <= new_ratio_i;
  end

  assign half_up  = (ratio_q + ratio_t'(1)) >> 1;
  assign strobe_o = tc;
  assign square_o = (cnt_q >= half_up);

  a_r3_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);

  a_r3_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc |=> (cnt_q == $past(cnt_q) - ratio_t'(1)));

  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc |=> (ratio_q == $past(new_ratio_i)) && (cnt_q == ratio_q - ratio_t'(1)));

  a_r5_ratio_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc |=> $stable(ratio_q));

  a_r6_square_low_at_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc |-> !square_o);
endmodule

// File: rtl/rdiv_cmp_divider.sv
module rdiv_cmp_divider
  import rdiv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             strobe_o,
  output logic             square_o
);
  logic   rst_n_sync;
  ratio_t sel_ratio;

  rdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  rdiv_ratio_dec u_dec (
    .sel_i   (sel_i),
    .ratio_o (sel_ratio)
  );

  rdiv_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .new_ratio_i (sel_ratio),
    .strobe_o    (strobe_o),
    .square_o    (square_o)
  );
endmodule

// File: tb/test_rdiv_cmp_divider.sv
`timescale 1ns/1ps
module test_rdiv_cmp_divider;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [3:0] sel_i;
  logic       strobe_o;
  logic       square_o;

  rdiv_cmp_divider i_rdiv_cmp_divider (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .strobe_o (strobe_o),
    .square_o (square_o)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  bit mon_en = 1'b0;
  bit have_prev = 1'b0;
  int len = 0;
  int hi = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int exp_ratio(input int sel);
    int k = sel & 7;
    if (((sel >> 3) & 1) == 0) return 2 << k;
    if (k == 0) return 3;
    return 5 << (k - 1);
  endfunction

  // monitor: measures period length and square high-time at each strobe
  always @(negedge clk) begin
    if (mon_en) begin
      if (have_prev) begin
        len++;
        if (square_o) hi++;
      end
      if (strobe_o) begin
        if (have_prev) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 strobe with no expected period", len, 0);
          end else begin
            int e;
            e = exp_q.pop_front();
            chk(len == e, ((e & (e - 1)) == 0) ? "R1 period length" : "R2 period length", len, e);
            chk(hi == e / 2, "R6 square high-time", hi, e / 2);
          end
        end
        len = 0;
        hi = 0;
        have_prev = 1'b1;
      end
    end
  end

  // driver: applies a select at a strobe (R4), optional mid-period glitch (R5)
  task automatic step(input int sel, input bit glitch);
    do @(negedge clk); while (!strobe_o);
    sel_i = sel[3:0];
    exp_q.push_back(exp_ratio(sel));
    if (glitch) begin
      @(negedge clk);
      sel_i = ~sel[3:0];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    sel_i  = 4'hF;
    repeat (3) @(negedge clk);
    chk(strobe_o == 1'b0, "R7 strobe in reset", strobe_o, 0);
    chk(square_o == 1'b1, "R7 square in reset", square_o, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(strobe_o == 1'b0, "R7 no strobe after edge 1", strobe_o, 0);
    @(negedge clk);
    chk(strobe_o == 1'b0, "R7 no strobe after edge 2", strobe_o, 0);
    chk(square_o == 1'b1, "R7 square before first strobe", square_o, 1);
    mon_en = 1'b1;
    @(negedge clk);
    chk(strobe_o == 1'b1, "R7 first strobe after edge 3", strobe_o, 1);
    // sel_i = F is captured on the edge closing this strobe (R4)
    exp_q.push_back(exp_ratio(15));

    for (int s = 0; s < 16; s++) step(s, (s % 3) == 1);
    step(15, 1'b1);
    step(0, 1'b0);
    step(8, 1'b1);
    step(7, 1'b0);
    step(9, 1'b1);
    step(9, 1'b1);
    step(1, 1'b0);
    step(11, 1'b1);
    step(3, 1'b0);

    while (exp_q.size() != 0) @(negedge clk);
    mon_en = 1'b0;

    // R8: asynchronous reset while square is low mid-period (ratio 16)
    do @(negedge clk); while (strobe_o || square_o);
    rst_ni = 1'b0;
    #0.5;
    chk(square_o == 1'b1, "R8 async square reset", square_o, 1);
    chk(strobe_o == 1'b0, "R8 async strobe reset", strobe_o, 0);

    summary();
    $finish;
  end
endmodule